// File: doc/BRIEF.md
# Serial Programmer Command Interpreter

This block sits between a byte-stream receiver and transmitter (for example a UART) and a downstream engine that performs target memory accesses. Each command is a single ASCII letter, optionally followed by argument bytes. The block collects the arguments and keeps a selected device code and a 16-bit target address. It decides whether the command may run, issues one request to the memory engine or to the entry sequencer, and sends back a reply. A successful command without a data reply ends with a carriage return (0x0D). A refused command gets '?' (0x3F). Reads return raw data bytes.

The identification commands and device selection are always accepted. Every other command needs a stored device code that appears in the parameter list of supported codes. That same list is what the listing command returns. Memory reads, data writes and high-byte program writes advance the address by one after they complete.

Top module: `prog_cmd_ctrl`

## Requirements
- R1: After reset, `rx_ready_o` is 1 and `tx_valid_o`, `mem_req_o` and `enter_req_o` are 0. The stored address is 0x0000 and the stored device code is 0x00, which is not in the default list, so every gated command is refused.
- R2: An ESC byte (0x1B) received while idle produces no reply and no request, and the block stays ready for the next command.
- R3: 'T' takes one argument byte, stores it as the device code and replies 0x0D. 'x' and 'y' reply 0x0D whatever device code is stored.
- R4: 'S' replies with the seven characters of `ID_STR`, first character first. 'V' replies with the two characters of `SW_VER`. 'v' replies with the two characters of `HW_VER`. 'p' replies 'S' (0x53).
- R5: 't' replies with every entry of `DEV_LIST`, entry 0 first (entry k sits in bits 8k+7..8k), and then 0x00.
- R6: The gated letters are A c C R D d e m L P. When the stored code is not in `DEV_LIST`, a gated letter is answered with '?' at once and none of its argument bytes is consumed. Any letter the block does not know is always answered with '?'.
- R7: 'A' takes two argument bytes, high byte first, loads them as the address and replies 0x0D. The next memory request carries that address.
- R8: 'R' issues one request with op code 0 at the current address. It replies with the high byte and then the low byte of `mem_rdata_i`, with no 0x0D afterwards, and the address then increments by one.
- R9: 'd' (op 1) replies with `mem_rdata_i[7:0]`. 'D' (op 2) and 'C' (op 4) each take one data byte, write it and reply 0x0D. All three increment the address by one, with carry from the low byte into the high byte, and 0xFFFF wraps to 0x0000. 'c' (op 3) writes its data byte and replies 0x0D but leaves the address unchanged.
- R10: 'm' (op 5), 'e' (op 6) and 'L' (op 7) each issue exactly one memory request and reply 0x0D. 'P' raises `enter_req_o` until `enter_done_i` and then replies 0x0D.
- R11: While `tx_valid_o` is high and `tx_ready_i` is low, `tx_valid_o` and `tx_data_o` hold. `rx_ready_o` is low from the cycle after a command's last byte until its reply has been fully sent.
- R12: `mem_req_o`, `mem_op_o`, `mem_addr_o` and `mem_wdata_o` stay stable from the rise of the request until the cycle in which `mem_ack_i` is seen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_valid_i | input | 1 | Received byte valid |
| rx_data_i | input | 8 | Received byte |
| rx_ready_o | output | 1 | Block accepts a received byte |
| tx_valid_o | output | 1 | Reply byte valid |
| tx_data_o | output | 8 | Reply byte |
| tx_ready_i | input | 1 | Transmitter takes the reply byte |
| mem_req_o | output | 1 | Memory engine request, held until acknowledged |
| mem_op_o | output | 3 | Operation code (0 read program, 1 read data, 2 write data, 3 write program low, 4 write program high, 5 page write, 6 erase, 7 leave) |
| mem_addr_o | output | ADDR_W | Target address of the request |
| mem_wdata_o | output | 8 | Write data byte |
| mem_ack_i | input | 1 | One-cycle completion pulse from the memory engine |
| mem_rdata_i | input | 16 | Read data, valid together with `mem_ack_i` |
| enter_req_o | output | 1 | Request to the entry sequencer, held until done |
| enter_done_i | input | 1 | Entry sequence finished |

## Verification
The interesting collision is in the cycle where the memory acknowledge arrives. In that one edge the address register steps forward and the reply sequencer latches the read data. The reply must therefore carry the word fetched for the old address, while the next request must already use the new one. The bench provokes this with acknowledges after zero to three cycles, with reads that cross a 0x..FF boundary and with the wrap at 0xFFFF, all while the transmitter stalls at random. It judges the result by comparing both the returned bytes and the address of the following request against its own model of the address and of the data each address yields.

// File: rtl/prog_cmd_pkg.sv
package prog_cmd_pkg;

  typedef enum logic [2:0] {
    OP_RD_PROG = 3'd0,
    OP_RD_DATA = 3'd1,
    OP_WR_DATA = 3'd2,
    OP_WR_PLO  = 3'd3,
    OP_WR_PHI  = 3'd4,
    OP_PAGE    = 3'd5,
    OP_ERASE   = 3'd6,
    OP_LEAVE   = 3'd7
  } mem_op_e;

  typedef enum logic [3:0] {
    RK_CR, RK_ERR, RK_ID, RK_SWV, RK_HWV, RK_TYPE, RK_LIST, RK_RD16, RK_RD8
  } reply_e;

  typedef enum logic [2:0] {
    ST_CMD, ST_ARG, ST_MEM, ST_ENTER, ST_REPLY
  } ctrl_state_e;

  localparam logic [7:0] CH_ESC  = 8'h1B;
  localparam logic [7:0] CH_CR   = 8'h0D;
  localparam logic [7:0] CH_ERR  = 8'h3F;
  localparam logic [7:0] CH_TYPE = 8'h53;

endpackage

// File: rtl/prog_cmd_devlist.sv
module prog_cmd_devlist #(
  parameter int             DEV_NUM  = 4,
  parameter logic [DEV_NUM*8-1:0] DEV_LIST = 32'h664A3521,
  parameter int             CW       = 4
) (
  input  logic [7:0]    dev_i,
  input  logic [CW-1:0] idx_i,
  output logic          hit_o,
  output logic [7:0]    code_o
);

  logic [DEV_NUM-1:0] match;

  for (genvar k = 0; k < DEV_NUM; k++) begin : g_cmp
    assign match[k] = (dev_i == DEV_LIST[8*k +: 8]);
  end

  assign hit_o = |match;

  // index DEV_NUM (past the end) yields the 0x00 terminator
  always_comb begin
    code_o = 8'h00;
    for (int k = 0; k < DEV_NUM; k++) begin
      if (idx_i == CW'(k)) code_o = DEV_LIST[8*k +: 8];
    end
  end

endmodule

// File: rtl/prog_cmd_addr.sv
module prog_cmd_addr #(
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_val_i,
  input  logic              inc_i,
  output logic [ADDR_W-1:0] addr_o
);

  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      addr_q <= '0;
    else if (load_i)  addr_q <= load_val_i;
    else if (inc_i)   addr_q <= addr_q + 1'b1;
  end

  assign addr_o = addr_q;

  a_r9_inc_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !load_i) |=> (addr_o == $past(addr_o) + 1'b1));

  a_r7_load_val: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (addr_o == $past(load_val_i)));

  a_r12_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !inc_i) |=> $stable(addr_o));

endmodule

// File: rtl/prog_cmd_reply.sv
module prog_cmd_reply
  import prog_cmd_pkg::*;
#(
  parameter int          DEV_NUM = 4,
  parameter int          CW      = 4,
  parameter logic [55:0] ID_STR  = "BYTEPRG",
  parameter logic [15:0] SW_VER  = "14",
  parameter logic [15:0] HW_VER  = "20"
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  reply_e        kind_i,
  input  logic [15:0]   rdata_i,
  input  logic [7:0]    list_code_i,
  output logic [CW-1:0] list_idx_o,
  output logic          tx_valid_o,
  output logic [7:0]    tx_data_o,
  input  logic          tx_ready_i,
  output logic          done_o
);

  logic          busy_q;
  reply_e        kind_q;
  logic [15:0]   data_q;
  logic [CW-1:0] idx_q;
  logic [CW-1:0] last_idx;
  logic [7:0]    id_byte;

  always_comb begin
    case (kind_q)
      RK_ID:                    last_idx = CW'(6);
      RK_SWV, RK_HWV, RK_RD16:  last_idx = CW'(1);
      RK_LIST:                  last_idx = CW'(DEV_NUM);
      default:                  last_idx = '0;
    endcase
  end

  always_comb begin
    id_byte = 8'h00;
    for (int k = 0; k < 7; k++) begin
      if (idx_q == CW'(k)) id_byte = ID_STR[8*(6-k) +: 8];
    end
  end

  always_comb begin
    case (kind_q)
      RK_CR:   tx_data_o = CH_CR;
      RK_ERR:  tx_data_o = CH_ERR;
      RK_TYPE: tx_data_o = CH_TYPE;
      RK_ID:   tx_data_o = id_byte;
      RK_SWV:  tx_data_o = (idx_q == '0) ? SW_VER[15:8] : SW_VER[7:0];
      RK_HWV:  tx_data_o = (idx_q == '0) ? HW_VER[15:8] : HW_VER[7:0];
      RK_LIST: tx_data_o = list_code_i;
      RK_RD16: tx_data_o = (idx_q == '0) ? data_q[15:8] : data_q[7:0];
      RK_RD8:  tx_data_o = data_q[7:0];
      default: tx_data_o = CH_ERR;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      kind_q <= RK_CR;
      data_q <= '0;
      idx_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      kind_q <= kind_i;
      data_q <= rdata_i;
      idx_q  <= '0;
    end else if (busy_q && tx_ready_i) begin
      if (idx_q == last_idx) busy_q <= 1'b0;
      else                   idx_q  <= idx_q + 1'b1;
    end
  end

  assign tx_valid_o = busy_q;
  assign done_o     = busy_q && tx_ready_i && (idx_q == last_idx);
  assign list_idx_o = idx_q;

  a_r11_tx_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_data_o)));

  a_r11_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !tx_valid_o);

endmodule

// File: rtl/prog_cmd_ctrl.sv
module prog_cmd_ctrl
  import prog_cmd_pkg::*;
#(
  parameter int                   ADDR_W   = 16,
  parameter int                   DEV_NUM  = 4,
  parameter logic [DEV_NUM*8-1:0] DEV_LIST = 32'h664A3521,
  parameter logic [55:0]          ID_STR   = "BYTEPRG",
  parameter logic [15:0]          SW_VER   = "14",
  parameter logic [15:0]          HW_VER   = "20"
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_valid_i,
  input  logic [7:0]        rx_data_i,
  output logic              rx_ready_o,
  output logic              tx_valid_o,
  output logic [7:0]        tx_data_o,
  input  logic              tx_ready_i,
  output logic              mem_req_o,
  output logic [2:0]        mem_op_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [15:0]       mem_rdata_i,
  output logic              enter_req_o,
  input  logic              enter_done_i
);

  localparam int CW = $clog2(DEV_NUM + 8);

  ctrl_state_e state_q, state_d;
  logic [7:0]  cmd_q, cmd_d;
  logic [1:0]  arg_left_q, arg_left_d;
  logic [7:0]  arg_hi_q, arg_hi_d;
  mem_op_e     op_q, op_d;
  logic [7:0]  wdata_q, wdata_d;
  logic        inc_q, inc_d;
  reply_e      rk_mem_q, rk_mem_d;
  logic [7:0]  dev_q;

  logic        rx_fire;
  logic        rep_start, rep_done;
  reply_e      rep_kind;
  logic        dev_load, addr_load, addr_inc;
  logic        dev_hit;
  logic [CW-1:0] list_idx;
  logic [7:0]  list_code;
  logic [ADDR_W-1:0] addr;

  assign rx_ready_o = (state_q == ST_CMD) || (state_q == ST_ARG);
  assign rx_fire    = rx_valid_i && rx_ready_o;

  prog_cmd_devlist #(
    .DEV_NUM  (DEV_NUM),
    .DEV_LIST (DEV_LIST),
    .CW       (CW)
  ) i_devlist (
    .dev_i  (dev_q),
    .idx_i  (list_idx),
    .hit_o  (dev_hit),
    .code_o (list_code)
  );

  prog_cmd_addr #(
    .ADDR_W (ADDR_W)
  ) i_addr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (addr_load),
    .load_val_i (ADDR_W'({arg_hi_q, rx_data_i})),
    .inc_i      (addr_inc),
    .addr_o     (addr)
  );

  prog_cmd_reply #(
    .DEV_NUM (DEV_NUM),
    .CW      (CW),
    .ID_STR  (ID_STR),
    .SW_VER  (SW_VER),
    .HW_VER  (HW_VER)
  ) i_reply (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (rep_start),
    .kind_i      (rep_kind),
    .rdata_i     (mem_rdata_i),
    .list_code_i (list_code),
    .list_idx_o  (list_idx),
    .tx_valid_o  (tx_valid_o),
    .tx_data_o   (tx_data_o),
    .tx_ready_i  (tx_ready_i),
    .done_o      (rep_done)
  );

  always_comb begin
    state_d    = state_q;
    cmd_d      = cmd_q;
    arg_left_d = arg_left_q;
    arg_hi_d   = arg_hi_q;
    op_d       = op_q;
    wdata_d    = wdata_q;
    inc_d      = inc_q;
    rk_mem_d   = rk_mem_q;
    rep_start  = 1'b0;
    rep_kind   = RK_CR;
    dev_load   = 1'b0;
    addr_load  = 1'b0;
    addr_inc   = 1'b0;

    case (state_q)
      ST_CMD: begin
        if (rx_fire && rx_data_i != CH_ESC) begin
          cmd_d     = rx_data_i;
          state_d   = ST_REPLY;
          rep_start = 1'b1;
          rep_kind  = RK_ERR;
          wdata_d   = 8'h00;
          rk_mem_d  = RK_CR;
          inc_d     = 1'b0;
          case (rx_data_i)
            "T": begin rep_start = 1'b0; arg_left_d = 2'd1; state_d = ST_ARG; end
            "S": rep_kind = RK_ID;
            "V": rep_kind = RK_SWV;
            "v": rep_kind = RK_HWV;
            "t": rep_kind = RK_LIST;
            "p": rep_kind = RK_TYPE;
            "x", "y": rep_kind = RK_CR;
            default: begin
              // gated letters; arguments are not taken when refused
              if (dev_hit) begin
                case (rx_data_i)
                  "A": begin
                    rep_start = 1'b0; arg_left_d = 2'd2; state_d = ST_ARG;
                  end
                  "c", "C", "D": begin
                    rep_start = 1'b0; arg_left_d = 2'd1; state_d = ST_ARG;
                  end
                  "R": begin
                    rep_start = 1'b0; op_d = OP_RD_PROG; inc_d = 1'b1;
                    rk_mem_d = RK_RD16; state_d = ST_MEM;
                  end
                  "d": begin
                    rep_start = 1'b0; op_d = OP_RD_DATA; inc_d = 1'b1;
                    rk_mem_d = RK_RD8; state_d = ST_MEM;
                  end
                  "e": begin rep_start = 1'b0; op_d = OP_ERASE; state_d = ST_MEM; end
                  "m": begin rep_start = 1'b0; op_d = OP_PAGE;  state_d = ST_MEM; end
                  "L": begin rep_start = 1'b0; op_d = OP_LEAVE; state_d = ST_MEM; end
                  "P": begin rep_start = 1'b0; state_d = ST_ENTER; end
                  default: ;
                endcase
              end
            end
          endcase
        end
      end

      ST_ARG: begin
        if (rx_fire) begin
          if (arg_left_q == 2'd2) begin
            arg_hi_d   = rx_data_i;
            arg_left_d = 2'd1;
          end else begin
            arg_left_d = 2'd0;
            wdata_d    = rx_data_i;
            rk_mem_d   = RK_CR;
            case (cmd_q)
              "T": begin dev_load  = 1'b1; rep_start = 1'b1; state_d = ST_REPLY; end
              "A": begin addr_load = 1'b1; rep_start = 1'b1; state_d = ST_REPLY; end
              "c": begin op_d = OP_WR_PLO;  inc_d = 1'b0; state_d = ST_MEM; end
              "C": begin op_d = OP_WR_PHI;  inc_d = 1'b1; state_d = ST_MEM; end
              default: begin op_d = OP_WR_DATA; inc_d = 1'b1; state_d = ST_MEM; end
            endcase
          end
        end
      end

      ST_MEM: begin
        if (mem_ack_i) begin
          addr_inc  = inc_q;
          rep_start = 1'b1;
          rep_kind  = rk_mem_q;
          state_d   = ST_REPLY;
        end
      end

      ST_ENTER: begin
        if (enter_done_i) begin
          rep_start = 1'b1;
          state_d   = ST_REPLY;
        end
      end

      ST_REPLY: begin
        if (rep_done) state_d = ST_CMD;
      end

      default: state_d = ST_CMD;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_CMD;
      cmd_q      <= 8'h00;
      arg_left_q <= 2'd0;
      arg_hi_q   <= 8'h00;
      op_q       <= OP_RD_PROG;
      wdata_q    <= 8'h00;
      inc_q      <= 1'b0;
      rk_mem_q   <= RK_CR;
      dev_q      <= 8'h00;
    end else begin
      state_q    <= state_d;
      cmd_q      <= cmd_d;
      arg_left_q <= arg_left_d;
      arg_hi_q   <= arg_hi_d;
      op_q       <= op_d;
      wdata_q    <= wdata_d;
      inc_q      <= inc_d;
      rk_mem_q   <= rk_mem_d;
      if (dev_load) dev_q <= rx_data_i;
    end
  end

  assign mem_req_o   = (state_q == ST_MEM);
  assign mem_op_o    = op_q;
  assign mem_addr_o  = addr;
  assign mem_wdata_o = wdata_q;
  assign enter_req_o = (state_q == ST_ENTER);

  a_r11_rx_tx_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rx_ready_o && tx_valid_o));

  a_r6_mem_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> dev_hit);

  a_r6_enter_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enter_req_o |-> dev_hit);

  a_r12_mem_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=>
      (mem_req_o && $stable(mem_op_o) && $stable(mem_addr_o) && $stable(mem_wdata_o)));

  a_r10_enter_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enter_req_o && !enter_done_i) |=> enter_req_o);

  a_r12_single_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_ack_i && mem_req_o |=> !mem_req_o);

endmodule

// File: tb/test_prog_cmd_ctrl.sv
`timescale 1ns/1ps
module test_prog_cmd_ctrl;

  localparam int          DEV_NUM  = 4;
  localparam logic [31:0] DEV_LIST = 32'h664A3521;
  localparam logic [55:0] ID_STR   = "BYTEPRG";
  localparam logic [15:0] SW_VER   = "14";
  localparam logic [15:0] HW_VER   = "20";
  localparam logic [7:0]  ESC      = 8'h1B;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = 8'h00;
  logic        rx_ready_o;
  logic        tx_valid_o;
  logic [7:0]  tx_data_o;
  logic        tx_ready = 1'b0;
  logic        mem_req_o;
  logic [2:0]  mem_op_o;
  logic [15:0] mem_addr_o;
  logic [7:0]  mem_wdata_o;
  logic        mem_ack = 1'b0;
  logic [15:0] mem_rdata = 16'h0000;
  logic        enter_req_o;
  logic        enter_done = 1'b0;

  always #4 clk = ~clk;

  prog_cmd_ctrl #(
    .ADDR_W (16), .DEV_NUM (DEV_NUM), .DEV_LIST (DEV_LIST),
    .ID_STR (ID_STR), .SW_VER (SW_VER), .HW_VER (HW_VER)
  ) i_prog_cmd_ctrl (
    .clk_i (clk), .rst_ni (rst_n),
    .rx_valid_i (rx_valid), .rx_data_i (rx_data), .rx_ready_o (rx_ready_o),
    .tx_valid_o (tx_valid_o), .tx_data_o (tx_data_o), .tx_ready_i (tx_ready),
    .mem_req_o (mem_req_o), .mem_op_o (mem_op_o), .mem_addr_o (mem_addr_o),
    .mem_wdata_o (mem_wdata_o), .mem_ack_i (mem_ack), .mem_rdata_i (mem_rdata),
    .enter_req_o (enter_req_o), .enter_done_i (enter_done)
  );

  int  n_chk = 0;
  int  n_fail = 0;
  bit  finished = 0;
  int  tx_pct = 100;

  logic [7:0]  got_tx[$];
  logic [7:0]  exp_tx[$];
  logic [26:0] got_mem[$];
  logic [26:0] exp_mem[$];
  int          enter_cnt = 0;
  int          exp_enter = 0;

  logic [7:0]  m_dev = 8'h00;
  logic [15:0] m_addr = 16'h0000;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic bit dev_ok(input logic [7:0] d);
    for (int k = 0; k < DEV_NUM; k++) if (DEV_LIST[8*k +: 8] == d) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [15:0] prog_word(input logic [15:0] a);
    return {a[7:0] ^ 8'hA5, a[15:8] ^ 8'h3C};
  endfunction

  function automatic logic [7:0] data_byte(input logic [15:0] a);
    return a[7:0] + 8'h17 + a[15:8];
  endfunction

  function automatic bit is_write(input logic [2:0] op);
    return op == 3'd2 || op == 3'd3 || op == 3'd4;
  endfunction

  // transmitter with random stalls; byte recorded when it will fire at next edge
  logic       prev_stall = 1'b0;
  logic [7:0] prev_data = 8'h00;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall)
        chk(tx_valid_o && tx_data_o == prev_data, "R11", "stalled reply byte",
            int'(tx_data_o), int'(prev_data));
      tx_ready = (($urandom % 100) < tx_pct);
      if (tx_valid_o && tx_ready) got_tx.push_back(tx_data_o);
      prev_stall = tx_valid_o && !tx_ready;
      prev_data  = tx_data_o;
    end
  end

  // memory engine model
  int          mem_delay = 0;
  bit          mem_seen = 0;
  logic [26:0] mem_first;
  always @(negedge clk) begin
    if (mem_ack) begin
      mem_ack   = 1'b0;
      mem_seen  = 0;
      mem_delay = $urandom % 4;
    end else if (rst_n && mem_req_o) begin
      if (!mem_seen) begin
        mem_seen  = 1;
        mem_first = {mem_op_o, mem_addr_o, mem_wdata_o};
      end else begin
        chk({mem_op_o, mem_addr_o, mem_wdata_o} == mem_first, "R12", "request held",
            int'({mem_op_o, mem_addr_o, mem_wdata_o}), int'(mem_first));
      end
      if (mem_delay == 0) begin
        mem_ack = 1'b1;
        case (mem_op_o)
          3'd0:    mem_rdata = prog_word(mem_addr_o);
          3'd1:    mem_rdata = {8'hC3, data_byte(mem_addr_o)};
          default: mem_rdata = 16'($urandom);
        endcase
        got_mem.push_back({mem_op_o, mem_addr_o,
                           is_write(mem_op_o) ? mem_wdata_o : 8'h00});
      end else begin
        mem_delay--;
      end
    end
  end

  int enter_delay = 0;
  always @(negedge clk) begin
    if (enter_done) begin
      enter_done  = 1'b0;
      enter_delay = $urandom % 4;
    end else if (rst_n && enter_req_o) begin
      if (enter_delay == 0) begin
        enter_done = 1'b1;
        enter_cnt++;
      end else enter_delay--;
    end
  end

  task automatic send_byte(input logic [7:0] b);
    rx_data  = b;
    rx_valid = 1'b1;
    while (!rx_ready_o) @(negedge clk);
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic push_mem(input logic [2:0] op, input logic [7:0] wd);
    exp_mem.push_back({op, m_addr, is_write(op) ? wd : 8'h00});
  endtask

  function automatic string tag_of(input logic [7:0] c);
    case (c)
      ESC: return "R2";
      "T", "x", "y": return "R3";
      "S", "V", "v", "p": return "R4";
      "t": return "R5";
      "A": return dev_ok(m_dev) ? "R7" : "R6";
      "R": return dev_ok(m_dev) ? "R8" : "R6";
      "d", "D", "C", "c": return dev_ok(m_dev) ? "R9" : "R6";
      "e", "m", "L", "P": return dev_ok(m_dev) ? "R10" : "R6";
      default: return "R6";
    endcase
  endfunction

  task automatic run_cmd(input logic [7:0] c, input logic [7:0] a1, input logic [7:0] a2);
    int    nargs = 0;
    string tag = tag_of(c);
    bit    gated = 0;
    case (c)
      ESC: ;
      "T": begin nargs = 1; m_dev = a1; exp_tx.push_back(8'h0D); end
      "S": for (int k = 6; k >= 0; k--) exp_tx.push_back(ID_STR[8*k +: 8]);
      "V": begin exp_tx.push_back(SW_VER[15:8]); exp_tx.push_back(SW_VER[7:0]); end
      "v": begin exp_tx.push_back(HW_VER[15:8]); exp_tx.push_back(HW_VER[7:0]); end
      "p": exp_tx.push_back(8'h53);
      "t": begin
        for (int k = 0; k < DEV_NUM; k++) exp_tx.push_back(DEV_LIST[8*k +: 8]);
        exp_tx.push_back(8'h00);
      end
      "x", "y": exp_tx.push_back(8'h0D);
      default: gated = 1;
    endcase
    if (gated) begin
      if (!dev_ok(m_dev)) exp_tx.push_back(8'h3F);
      else case (c)
        "A": begin nargs = 2; m_addr = {a1, a2}; exp_tx.push_back(8'h0D); end
        "c": begin nargs = 1; push_mem(3'd3, a1); exp_tx.push_back(8'h0D); end
        "C": begin nargs = 1; push_mem(3'd4, a1); m_addr++; exp_tx.push_back(8'h0D); end
        "D": begin nargs = 1; push_mem(3'd2, a1); m_addr++; exp_tx.push_back(8'h0D); end
        "R": begin
          push_mem(3'd0, 8'h00);
          exp_tx.push_back(prog_word(m_addr)[15:8]);
          exp_tx.push_back(prog_word(m_addr)[7:0]);
          m_addr++;
        end
        "d": begin push_mem(3'd1, 8'h00); exp_tx.push_back(data_byte(m_addr)); m_addr++; end
        "e": begin push_mem(3'd6, 8'h00); exp_tx.push_back(8'h0D); end
        "m": begin push_mem(3'd5, 8'h00); exp_tx.push_back(8'h0D); end
        "L": begin push_mem(3'd7, 8'h00); exp_tx.push_back(8'h0D); end
        "P": begin exp_enter++; exp_tx.push_back(8'h0D); end
        default: exp_tx.push_back(8'h3F);
      endcase
    end
    send_byte(c);
    if (nargs >= 1) send_byte(a1);
    if (nargs == 2) send_byte(a2);
    if (c != ESC) chk(!rx_ready_o, "R11", "rx_ready low while busy", int'(rx_ready_o), 0);
    while (!rx_ready_o) @(negedge clk);
    chk(got_tx.size() == exp_tx.size(), tag, $sformatf("reply length for %c", c),
        got_tx.size(), exp_tx.size());
    for (int k = 0; k < got_tx.size() && k < exp_tx.size(); k++)
      chk(got_tx[k] == exp_tx[k], tag, $sformatf("reply byte %0d for %c", k, c),
          int'(got_tx[k]), int'(exp_tx[k]));
    chk(got_mem.size() == exp_mem.size(), tag, "request count",
        got_mem.size(), exp_mem.size());
    for (int k = 0; k < got_mem.size() && k < exp_mem.size(); k++)
      chk(got_mem[k] == exp_mem[k], tag, "request op/addr/data",
          int'(got_mem[k]), int'(exp_mem[k]));
    chk(enter_cnt == exp_enter, tag, "entry requests", enter_cnt, exp_enter);
    got_tx.delete(); exp_tx.delete(); got_mem.delete(); exp_mem.delete();
  endtask

  initial begin
    int    seed_init;
    string pool = "TSVvtpxyLPAcCRDdemQ";
    seed_init = $urandom(32'd20117);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rx_ready_o == 1'b1, "R1", "rx_ready after reset", int'(rx_ready_o), 1);
    chk(tx_valid_o == 1'b0, "R1", "tx_valid after reset", int'(tx_valid_o), 0);
    chk(mem_req_o == 1'b0, "R1", "mem_req after reset", int'(mem_req_o), 0);
    chk(enter_req_o == 1'b0, "R1", "enter_req after reset", int'(enter_req_o), 0);

    tx_pct = 100;
    run_cmd("R", 8'h00, 8'h00);          // R1/R6: device 0 refused
    run_cmd("A", 8'h12, 8'h34);          // R6: refused, args not taken
    run_cmd(ESC, 8'h00, 8'h00);          // R2
    run_cmd("S", 8'h00, 8'h00);          // R4
    run_cmd("Q", 8'h00, 8'h00);          // R6 unknown
    run_cmd("T", 8'h35, 8'h00);          // R3
    tx_pct = 40;
    run_cmd("R", 8'h00, 8'h00);          // R1: address starts at 0
    run_cmd("A", 8'h12, 8'hFF);          // R7
    run_cmd("R", 8'h00, 8'h00);          // R8 carry to 0x1300
    run_cmd("d", 8'h00, 8'h00);          // R9
    run_cmd("c", 8'h77, 8'h00);          // R9 no increment
    run_cmd("C", 8'h88, 8'h00);          // R9
    run_cmd("A", 8'hFF, 8'hFF);
    run_cmd("D", 8'h5E, 8'h00);          // R9 wrap
    run_cmd("d", 8'h00, 8'h00);
    run_cmd("e", 8'h00, 8'h00);          // R10
    run_cmd("m", 8'h00, 8'h00);
    run_cmd("L", 8'h00, 8'h00);
    run_cmd("P", 8'h00, 8'h00);
    run_cmd("t", 8'h00, 8'h00);          // R5
    run_cmd("V", 8'h00, 8'h00);
    run_cmd("v", 8'h00, 8'h00);
    run_cmd("p", 8'h00, 8'h00);
    run_cmd("T", 8'h99, 8'h00);          // invalid code
    run_cmd("e", 8'h00, 8'h00);          // R6
    run_cmd("x", 8'h00, 8'h00);          // R3 still accepted
    run_cmd("y", 8'h00, 8'h00);

    for (int i = 0; i < 500; i++) begin
      int          k;
      logic [7:0]  c, a1, a2;
      tx_pct = 30 + ($urandom % 71);
      k  = $urandom % (pool.len() + 1);
      c  = (k == pool.len()) ? ESC : pool[k];
      a1 = 8'($urandom);
      a2 = ($urandom % 3 == 0) ? 8'hFF : 8'($urandom);
      if (c == "T" && ($urandom % 4 != 0)) a1 = DEV_LIST[8*($urandom % DEV_NUM) +: 8];
      run_cmd(c, a1, a2);
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL R11 watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule